// File: doc/BRIEF.md
# Sector Erase Queue with Acceptance Window

This block sits after a command decoder in a flash controller. When the decoder reports that a full sector-erase sequence has arrived, the block records that sector in a bitmap. It then opens an acceptance window, during which further single-cycle sector-erase commands (code 0x30) add more sectors. The window length is counted in timer ticks. A falling write-enable edge, or any accepted command, starts the count again from zero. When the window runs out, the block issues a one-cycle erase-start pulse and holds the sector mask for the erase engine until that engine reports completion.

During the window, a suspend command (0xB0) ends the window at once and launches the erase. Any other command, during the window or during the erase, cancels the operation and clears the mask. A status output stays low while the window is open and is high at all other times, so software can tell whether more sectors may still be added.

Top module: `sector_erase_queue`

## Requirements
- R1: After reset, `sector_mask` is all zero, `erase_start` is low and `dly_done` is high.
- R2: A `seq_start` pulse in the idle state sets exactly the bit of `cmd_sector` in `sector_mask` and opens the window. `dly_done` reads low from the next cycle onward.
- R3: While the window is open, a `cmd_valid` cycle with `cmd_code` = 0x30 sets bit `cmd_sector` of the mask. Sectors may arrive in any order. Selecting a sector that is already set leaves the mask unchanged.
- R4: At most MAX_SEL (default 8) bits of the mask are ever set. A further distinct sector that arrives once the limit is reached is not loaded.
- R5: The window expires on the WINDOW_TICKS-th `tick` after the most recent restart. The cycle after that tick shows `erase_start` high for exactly one cycle, `dly_done` high, and the mask held.
- R6: A `we_fall` pulse, or any `cmd_valid`, during the window resets the tick count to zero.
- R7: `cmd_valid` with `cmd_code` = 0xB0 while the window is open ends the window at once. `erase_start` is high in the following cycle.
- R8: `cmd_valid` with any code other than 0x30 or 0xB0, during the window or during the erase, clears the mask, gives no `erase_start`, and returns the block to idle with `dly_done` high.
- R9: A 0x30 command that arrives after the window has closed (the erase is running) does not change the mask.
- R10: `erase_done` during the erase clears the mask and returns the block to idle.
- R11: In the idle state, `cmd_valid` has no effect: the mask stays zero and `dly_done` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_start | input | 1 | Decoder finished a full sector-erase sequence for `cmd_sector` |
| cmd_valid | input | 1 | One decoded single-cycle command, latched at the write-enable rising edge |
| cmd_code | input | 8 | Command code that goes with `cmd_valid` |
| cmd_sector | input | SECT_W | Sector index for `seq_start` or for a 0x30 command |
| we_fall | input | 1 | Write-enable falling edge, one cycle |
| tick | input | 1 | Time base for the window, one cycle per tick |
| erase_done | input | 1 | Erase engine finished |
| sector_mask | output | NUM_SECTORS | Bitmap of the selected sectors |
| erase_start | output | 1 | One-cycle launch pulse |
| dly_done | output | 1 | Low while the window is open |

## Verification
The queue is driven with several input patterns:
- a single sector that runs to a natural expiry;
- several sectors in mixed order, including a repeat;
- a write-enable edge in the middle of the window;
- more distinct sectors than the limit allows;
- a suspend partway through the window;
- foreign commands, both during the window and during the erase.

The natural-expiry case checks the exact tick on which the launch happens. The restart case tells a counter that truly resets apart from one that only pauses: the launch must land on the full count after the edge, not on the remainder. The limit case and the repeat case separate counting distinct sectors from counting commands. The late-command and idle cases show that 0x30 is honoured only while the window is open.

// File: rtl/seq_pkg.sv
// Shared types and command codes for the sector erase queue.
package seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_ERASE  = 2'd2
    } q_state_t;

    localparam logic [7:0] CODE_SECTOR  = 8'h30;
    localparam logic [7:0] CODE_SUSPEND = 8'hB0;
endpackage

// File: rtl/window_timer.sv
// Acceptance window counter.
// Counts ticks while run is high and clears on restart. expire is high on
// the tick that completes TICKS counts.
// Assumes tick, restart and run are synchronous single-cycle qualifiers.
module window_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt;

    // Final tick of the window: running, not restarted, count at its last value.
    assign expire = run && !restart && tick && (cnt == CW'(TICKS - 1));

    // Tick counter: held at zero when idle or restarted, wraps on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TICKS)) else $error("window count out of range"); // R5

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0)) else $error("restart did not clear count"); // R6
endmodule

// File: rtl/sector_bitmap.sv
// Sector selection bitmap.
// load_first replaces the map with one sector. add_en sets a further bit,
// unless that bit is already set or MAX_SEL bits are set. clear empties the map.
// Assumes at most one of load_first, add_en and clear is high in a cycle.
module sector_bitmap #(
    parameter int NUM_SECTORS = 16,
    parameter int MAX_SEL     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_first,
    input  logic                           add_en,
    input  logic                           clear,
    input  logic [$clog2(NUM_SECTORS)-1:0] sector,
    output logic [NUM_SECTORS-1:0]         mask
);
    localparam int SW  = $clog2(NUM_SECTORS);
    localparam int CNW = $clog2(NUM_SECTORS + 1);

    logic [CNW-1:0] sel_count;
    logic           full;

    // Number of sectors currently selected.
    always_comb begin
        sel_count = '0;
        for (int i = 0; i < NUM_SECTORS; i++) begin
            sel_count = sel_count + CNW'(mask[i]);
        end
    end

    assign full = (sel_count >= CNW'(MAX_SEL));

    // One flop per sector bit.
    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_bit
        logic hit;
        assign hit = (sector == SW'(g));

        // Per-bit update: clear or first load rewrites it, add only sets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[g] <= 1'b0;
            end else if (clear) begin
                mask[g] <= 1'b0;
            end else if (load_first) begin
                mask[g] <= hit;
            end else if (add_en && hit && !full) begin
                mask[g] <= 1'b1;
            end
        end
    end

    AST_SEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) <= MAX_SEL) else $error("too many sectors"); // R4

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mask == '0)) else $error("clear left bits set"); // R8

    AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        load_first |=> ($countones(mask) == 1)) else $error("first load not one-hot"); // R2
endmodule

// File: rtl/queue_ctrl.sv
// Queue sequencing state machine.
// Idle -> window on a full sequence. Window -> erase on expiry or suspend.
// A foreign command in the window or the erase returns to idle and clears.
// erase_done returns to idle from the erase.
// Assumes cmd_valid and seq_start are single-cycle and never both high.
module queue_ctrl
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_start,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       we_fall,
    input  logic       erase_done,
    input  logic       expire,
    output logic       run,
    output logic       restart,
    output logic       load_first,
    output logic       add_en,
    output logic       clear,
    output logic       erase_start,
    output logic       dly_done
);
    q_state_t state, state_nx;
    logic     is_sector, is_susp, is_other, launch;

    // Command classification.
    assign is_sector = (cmd_code == CODE_SECTOR);
    assign is_susp   = (cmd_code == CODE_SUSPEND);
    assign is_other  = !is_sector && !is_susp;

    // Datapath strobes derived from state and the incoming command.
    always_comb begin
        run        = (state == ST_WINDOW);
        restart    = run && (we_fall || cmd_valid);
        load_first = (state == ST_IDLE) && seq_start;
        add_en     = run && cmd_valid && is_sector;
        launch     = run && ((cmd_valid && is_susp) || (!cmd_valid && expire));
        clear      = ((state != ST_IDLE) && cmd_valid && is_other)
                   || ((state == ST_ERASE) && erase_done);
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (seq_start) state_nx = ST_WINDOW;
            ST_WINDOW: if (clear) state_nx = ST_IDLE;
                       else if (launch) state_nx = ST_ERASE;
            ST_ERASE:  if (clear) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and registered launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            erase_start <= 1'b0;
        end else begin
            state       <= state_nx;
            erase_start <= launch && !clear;
        end
    end

    assign dly_done = (state != ST_WINDOW);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start) else $error("start longer than a cycle"); // R5

    AST_START_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> dly_done) else $error("start with window open"); // R5

    AST_SUSP_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!dly_done && cmd_valid && cmd_code == CODE_SUSPEND) |=> erase_start)
        else $error("suspend did not launch"); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !seq_start) |=> (state == ST_IDLE))
        else $error("left idle without a sequence"); // R11
endmodule

// File: rtl/sector_erase_queue.sv
// Top of the sector erase queue: controller, window timer and sector bitmap.
// Assumes decoded inputs are synchronous one-cycle pulses on clk.
module sector_erase_queue #(
    parameter int NUM_SECTORS  = 16,
    parameter int MAX_SEL      = 8,
    parameter int WINDOW_TICKS = 16,
    localparam int SECT_W      = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   seq_start,
    input  logic                   cmd_valid,
    input  logic [7:0]             cmd_code,
    input  logic [SECT_W-1:0]      cmd_sector,
    input  logic                   we_fall,
    input  logic                   tick,
    input  logic                   erase_done,
    output logic [NUM_SECTORS-1:0] sector_mask,
    output logic                   erase_start,
    output logic                   dly_done
);
    logic run, restart, expire, load_first, add_en, clear;

    queue_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .we_fall(we_fall), .erase_done(erase_done),
        .expire(expire), .run(run), .restart(restart), .load_first(load_first),
        .add_en(add_en), .clear(clear), .erase_start(erase_start),
        .dly_done(dly_done)
    );

    window_timer #(.TICKS(WINDOW_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .tick(tick),
        .expire(expire)
    );

    sector_bitmap #(.NUM_SECTORS(NUM_SECTORS), .MAX_SEL(MAX_SEL)) u_map (
        .clk(clk), .rst_n(rst_n), .load_first(load_first), .add_en(add_en),
        .clear(clear), .sector(cmd_sector), .mask(sector_mask)
    );

    AST_START_HAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (sector_mask != '0)) else $error("launch with empty mask"); // R5

    AST_LATE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_done && !seq_start && !clear) |=> $stable(sector_mask) || (sector_mask == '0))
        else $error("mask changed outside window"); // R9
endmodule

// File: tb/sim_sector_erase_queue.sv
module sim_sector_erase_queue;
    localparam int NS = 16;
    localparam int WT = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic seq_start = 0, cmd_valid = 0, we_fall = 0, tick = 0, erase_done = 0;
    logic [7:0] cmd_code = 8'h00;
    logic [3:0] cmd_sector = 4'd0;
    logic [NS-1:0] sector_mask;
    logic erase_start, dly_done;
    int checks = 0, failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sector_erase_queue #(.NUM_SECTORS(NS), .MAX_SEL(8), .WINDOW_TICKS(WT)) u0 (
        .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_sector(cmd_sector), .we_fall(we_fall),
        .tick(tick), .erase_done(erase_done), .sector_mask(sector_mask),
        .erase_start(erase_start), .dly_done(dly_done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_seq(logic [3:0] s);
        @(negedge clk); seq_start = 1; cmd_sector = s;
        @(negedge clk); seq_start = 0;
    endtask

    task automatic do_cmd(logic [7:0] c, logic [3:0] s);
        @(negedge clk); cmd_valid = 1; cmd_code = c; cmd_sector = s;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic do_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
        end
        @(negedge clk); tick = 0;
    endtask

    task automatic do_wefall();
        @(negedge clk); we_fall = 1;
        @(negedge clk); we_fall = 0;
    endtask

    task automatic do_done();
        @(negedge clk); erase_done = 1;
        @(negedge clk); erase_done = 0;
    endtask

    // Expect exactly one start: sampled now, then gone a cycle later.
    task automatic expect_start(string req);
        chk(req, {31'd0, erase_start}, 32'd1);
        chk(req, {31'd0, dly_done}, 32'd1);
        @(negedge clk);
        chk(req, {31'd0, erase_start}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 mask", 32'(sector_mask), 32'h0);
        chk("R1 start", {31'd0, erase_start}, 32'd0);
        chk("R1 status", {31'd0, dly_done}, 32'd1);
    endtask

    task automatic t_single();
        do_seq(4'd3);
        chk("R2 mask", 32'(sector_mask), 32'h0008);
        chk("R2 status", {31'd0, dly_done}, 32'd0);
        do_ticks(WT - 1);
        chk("R5 early", {31'd0, erase_start}, 32'd0);
        chk("R5 open", {31'd0, dly_done}, 32'd0);
        do_ticks(1);
        expect_start("R5 expiry");
        chk("R5 mask held", 32'(sector_mask), 32'h0008);
        do_done();
        chk("R10 done", 32'(sector_mask), 32'h0);
        chk("R10 status", {31'd0, dly_done}, 32'd1);
    endtask

    task automatic t_multi_restart();
        do_seq(4'd5);
        do_cmd(8'h30, 4'd1);
        do_cmd(8'h30, 4'd12);
        do_cmd(8'h30, 4'd5);
        chk("R3 any order and repeat", 32'(sector_mask), 32'h1022);
        do_ticks(3);
        do_wefall();
        do_ticks(WT - 1);
        chk("R6 restart no early start", {31'd0, erase_start}, 32'd0);
        chk("R6 still open", {31'd0, dly_done}, 32'd0);
        do_ticks(1);
        expect_start("R6 start after full count");
        do_cmd(8'h30, 4'd7);
        chk("R9 late not loaded", 32'(sector_mask), 32'h1022);
        do_cmd(8'hF0, 4'd0);
        chk("R8 abort during erase", 32'(sector_mask), 32'h0);
        chk("R8 status", {31'd0, dly_done}, 32'd1);
    endtask

    task automatic t_limit();
        do_seq(4'd0);
        for (int i = 1; i < 8; i++) do_cmd(8'h30, 4'(i));
        chk("R4 eight loaded", 32'(sector_mask), 32'h00FF);
        do_cmd(8'h30, 4'd9);
        chk("R4 ninth dropped", 32'(sector_mask), 32'h00FF);
        do_cmd(8'h30, 4'd9);
        chk("R4 ninth again dropped", 32'(sector_mask), 32'h00FF);
        do_ticks(WT);
        expect_start("R5 limit run");
        do_done();
    endtask

    task automatic t_suspend();
        do_seq(4'd4);
        do_ticks(2);
        do_cmd(8'hB0, 4'd0);
        expect_start("R7 suspend");
        chk("R7 mask", 32'(sector_mask), 32'h0010);
        do_done();
    endtask

    task automatic t_abort_window();
        do_seq(4'd14);
        do_cmd(8'h90, 4'd0);
        chk("R8 abort in window", 32'(sector_mask), 32'h0);
        chk("R8 status", {31'd0, dly_done}, 32'd1);
        chk("R8 no start", {31'd0, erase_start}, 32'd0);
        do_ticks(WT + 2);
        chk("R8 no later start", {31'd0, erase_start}, 32'd0);
    endtask

    task automatic t_idle();
        do_cmd(8'h30, 4'd3);
        chk("R11 idle mask", 32'(sector_mask), 32'h0);
        do_cmd(8'hB0, 4'd3);
        chk("R11 idle status", {31'd0, dly_done}, 32'd1);
        chk("R11 idle no start", {31'd0, erase_start}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi_restart();
        t_limit();
        t_suspend();
        t_abort_window();
        t_idle();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule